// File: doc/BRIEF.md
# General-Purpose Input Event Router

This block turns per-input status events from up to sixteen general-purpose inputs into three system request levels: a system-management interrupt request, a system-control interrupt request and a wake request. A 32-bit routing register holds a 2-bit route code for each input. Input n uses bits [2n+1:2n]. A code of 01 steers the input to the management interrupt, a code of 10 steers it to the control interrupt, and codes 00 and 11 steer it nowhere. Each route is further gated by a per-input enable vector. The management path uses the SMI-enable vector and the control path uses the GPE-enable vector.

The wake path does not depend on the route code. While the platform reports a sleep state, any input whose status bit and GPE-enable bit are both set requests wake. A pin configured as an output takes no part in any path. Inputs that are not implemented also take no part, and the parameter `IMPL_MASK` selects which inputs are implemented. The routing register is accessed through a plain register port with per-byte write enables and a combinational read. There is no valid/ready handshake: the register port and all event pins are control and status signals, so no back-pressure rules apply. All three outputs are combinational levels. They follow the inputs in the same cycle and hold for as long as a qualifying status bit stays set.

Top module: `gpi_event_router`

## Requirements
- R1: After reset (active-low `rst_n`) the routing register reads as all zeros and no request output is asserted.
- R2: A write with `wr_en` high updates, at the next rising clock edge, each byte k of the register for which `wr_be[k]` is set, taking it from `wr_data[8k+7:8k]`. Bytes whose enable is clear keep their value. With `wr_en` low the register does not change. `rd_data` always shows the current register value.
- R3: The 2-bit field of any input whose `IMPL_MASK` bit is 0 always reads 00 and ignores writes. With the default mask, input 14 (bits 29:28) is unimplemented.
- R4: `smi_req` is high when some input has route code 01 and its status bit, its direction bit, its SMI-enable bit and its implemented bit are all 1.
- R5: `sci_req` is high when some input has route code 10 and its status bit, its direction bit, its GPE-enable bit and its implemented bit are all 1.
- R6: Route codes 00 and 11 never make an input contribute to `smi_req` or `sci_req`.
- R7: An input whose `gpi_is_input` bit is 0 (pin configured as output) contributes to no output, whatever its route code and enables.
- R8: An input whose status bit is 0 contributes to no output. With all status bits 0, all three outputs are low.
- R9: `wake_req` is high when `sleeping` is 1 and some implemented input has its status, direction and GPE-enable bits all set, whatever its route code. When `sleeping` is 0, `wake_req` is low.
- R10: Each output is the OR over all inputs of that input's qualified request. It is combinational and tracks input changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Per-byte write enables |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current routing register value |
| gpi_sts | input | 16 | Per-input event status bits |
| gpi_is_input | input | 16 | 1 = pin configured as input |
| smi_en | input | 16 | Per-input management interrupt enables |
| gpe_en | input | 16 | Per-input control interrupt / wake enables |
| sleeping | input | 1 | 1 = system is in a sleep state S1 to S5 |
| smi_req | output | 1 | Management interrupt request level |
| sci_req | output | 1 | Control interrupt request level |
| wake_req | output | 1 | Wake request level |

## Verification
The assertions check four things on every cycle:
- Any asserted interrupt request is backed by at least one input with status, direction, enable and implemented bits all set.
- Wake is never requested while the system is awake.
- All outputs are quiet when no status bit is set.
- Unimplemented fields read zero, and the register holds still without a write.

Other behaviour shows only in the bench scenarios: which exact route code maps to which output, that reserved code 11 stays silent, that a route code of 00 still allows wake, and that byte enables leave the other bytes intact. The bench checks these against a reference model that is fed the same random and directed patterns.

// File: rtl/gpi_route_pkg.sv
package gpi_route_pkg;

  localparam int ROUTE_W = 2;

  typedef enum logic [ROUTE_W-1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_SMI  = 2'b01,
    ROUTE_SCI  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

endpackage

// File: rtl/gpi_route_reg.sv
module gpi_route_reg
  import gpi_route_pkg::*;
#(
  parameter int               NUM_GPI   = 16,
  parameter logic [NUM_GPI-1:0] IMPL_MASK = '1,
  localparam int REG_W  = NUM_GPI * ROUTE_W,
  localparam int NBYTES = REG_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data
);

  function automatic logic [REG_W-1:0] field_keep(input logic [NUM_GPI-1:0] m);
    logic [REG_W-1:0] k;
    k = '0;
    for (int i = 0; i < NUM_GPI; i++) k[i*ROUTE_W +: ROUTE_W] = {ROUTE_W{m[i]}};
    return k;
  endfunction

  localparam logic [REG_W-1:0] KEEP = field_keep(IMPL_MASK);

  logic [7:0] byte_q [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q[b] <= '0;
      else if (wr_en && wr_be[b])
        byte_q[b] <= wr_data[b*8 +: 8] & KEEP[b*8 +: 8];
    end
    assign rd_data[b*8 +: 8] = byte_q[b];
  end

  AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~KEEP) == '0); // R3
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R2

endmodule

// File: rtl/gpi_route_qual.sv
module gpi_route_qual
  import gpi_route_pkg::*;
#(
  parameter int                 NUM_GPI   = 16,
  parameter logic [NUM_GPI-1:0] IMPL_MASK = '1,
  localparam int REG_W = NUM_GPI * ROUTE_W
) (
  input  logic [REG_W-1:0]   route_vec,
  input  logic [NUM_GPI-1:0] sts,
  input  logic [NUM_GPI-1:0] is_input,
  input  logic [NUM_GPI-1:0] smi_en,
  input  logic [NUM_GPI-1:0] gpe_en,
  input  logic               sleeping,
  output logic [NUM_GPI-1:0] smi_hit,
  output logic [NUM_GPI-1:0] sci_hit,
  output logic [NUM_GPI-1:0] wake_hit
);

  for (genvar n = 0; n < NUM_GPI; n++) begin : g_in
    if (IMPL_MASK[n]) begin : g_impl
      route_e code;
      logic   live;
      assign code        = route_e'(route_vec[n*ROUTE_W +: ROUTE_W]);
      assign live        = sts[n] & is_input[n];
      assign smi_hit[n]  = live & smi_en[n] & (code == ROUTE_SMI);
      assign sci_hit[n]  = live & gpe_en[n] & (code == ROUTE_SCI);
      assign wake_hit[n] = live & gpe_en[n] & sleeping;
    end else begin : g_absent
      assign smi_hit[n]  = 1'b0;
      assign sci_hit[n]  = 1'b0;
      assign wake_hit[n] = 1'b0;
    end
  end

endmodule

// File: rtl/gpi_route_any.sv
module gpi_route_any #(
  parameter int W = 16
) (
  input  logic [W-1:0] hits,
  output logic         any
);
  assign any = |hits;
endmodule

// File: rtl/gpi_event_router.sv
module gpi_event_router
  import gpi_route_pkg::*;
#(
  parameter int                 NUM_GPI   = 16,
  parameter logic [NUM_GPI-1:0] IMPL_MASK = 16'hBFFF,
  localparam int REG_W  = NUM_GPI * ROUTE_W,
  localparam int NBYTES = REG_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NBYTES-1:0]  wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic [NUM_GPI-1:0] gpi_sts,
  input  logic [NUM_GPI-1:0] gpi_is_input,
  input  logic [NUM_GPI-1:0] smi_en,
  input  logic [NUM_GPI-1:0] gpe_en,
  input  logic               sleeping,
  output logic               smi_req,
  output logic               sci_req,
  output logic               wake_req
);

  logic [NUM_GPI-1:0] smi_hit, sci_hit, wake_hit;

  gpi_route_reg #(.NUM_GPI(NUM_GPI), .IMPL_MASK(IMPL_MASK)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  gpi_route_qual #(.NUM_GPI(NUM_GPI), .IMPL_MASK(IMPL_MASK)) u_qual (
    .route_vec(rd_data), .sts(gpi_sts), .is_input(gpi_is_input),
    .smi_en(smi_en), .gpe_en(gpe_en), .sleeping(sleeping),
    .smi_hit(smi_hit), .sci_hit(sci_hit), .wake_hit(wake_hit)
  );

  gpi_route_any #(.W(NUM_GPI)) u_any_smi  (.hits(smi_hit),  .any(smi_req));
  gpi_route_any #(.W(NUM_GPI)) u_any_sci  (.hits(sci_hit),  .any(sci_req));
  gpi_route_any #(.W(NUM_GPI)) u_any_wake (.hits(wake_hit), .any(wake_req));

  AST_SMI_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> |(gpi_sts & gpi_is_input & smi_en & IMPL_MASK)); // R4
  AST_SCI_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    sci_req |-> |(gpi_sts & gpi_is_input & gpe_en & IMPL_MASK)); // R5
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> sleeping); // R9
  AST_QUIET_WITHOUT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (gpi_sts == '0) |-> !(smi_req || sci_req || wake_req)); // R8

endmodule

// File: tb/tb_gpi_event_router.sv
`timescale 1ns/1ps
module tb_gpi_event_router;

  localparam logic [15:0] IMPL = 16'hBFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] gpi_sts = '0, gpi_is_input = '0, smi_en = '0, gpe_en = '0;
  logic        sleeping = 1'b0;
  logic        smi_req, sci_req, wake_req;

  logic [31:0] model;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpi_event_router dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .gpi_sts(gpi_sts), .gpi_is_input(gpi_is_input),
    .smi_en(smi_en), .gpe_en(gpe_en), .sleeping(sleeping),
    .smi_req(smi_req), .sci_req(sci_req), .wake_req(wake_req)
  );

  function automatic logic [31:0] keep_mask();
    logic [31:0] k = '0;
    for (int i = 0; i < 16; i++) k[2*i +: 2] = {2{IMPL[i]}};
    return k;
  endfunction

  function automatic logic want(input int kind, input logic [31:0] r,
      input logic [15:0] s, input logic [15:0] d, input logic [15:0] se,
      input logic [15:0] ge, input logic slp);
    logic hit = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (IMPL[i] && s[i] && d[i]) begin
        if (kind == 0 && r[2*i +: 2] == 2'b01 && se[i]) hit = 1'b1;
        if (kind == 1 && r[2*i +: 2] == 2'b10 && ge[i]) hit = 1'b1;
        if (kind == 2 && slp && ge[i]) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R4 smi_req"},  {31'd0, smi_req},
        {31'd0, want(0, model, gpi_sts, gpi_is_input, smi_en, gpe_en, sleeping)});
    chk({tag, " R5 sci_req"},  {31'd0, sci_req},
        {31'd0, want(1, model, gpi_sts, gpi_is_input, smi_en, gpe_en, sleeping)});
    chk({tag, " R9 wake_req"}, {31'd0, wake_req},
        {31'd0, want(2, model, gpi_sts, gpi_is_input, smi_en, gpe_en, sleeping)});
    chk({tag, " R2 rd_data"}, rd_data, model);
  endtask

  task automatic write_reg(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(posedge clk);
    for (int b = 0; b < 4; b++) if (be[b]) model[8*b +: 8] = d[8*b +: 8] & keep_mask()[8*b +: 8];
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; wr_data = $urandom;
    #1;
  endtask

  task automatic drive(input logic [15:0] s, input logic [15:0] d, input logic [15:0] se,
                       input logic [15:0] ge, input logic slp, input string tag);
    @(negedge clk);
    gpi_sts = s; gpi_is_input = d; smi_en = se; gpe_en = ge; sleeping = slp;
    #1;
    check_all(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset outputs", {29'd0, smi_req, sci_req, wake_req}, 32'h0);

    // R2 R3: full write, input 14 field masked
    write_reg(4'hF, 32'hFFFF_FFFF);
    chk("R3 unimpl field zero", rd_data, 32'hCFFF_FFFF);
    write_reg(4'h2, 32'h0000_5A00);
    chk("R2 byte enable", rd_data, 32'hCFFF_5AFF);
    @(negedge clk); wr_en = 1'b0; wr_data = 32'h0; @(posedge clk); #1;
    chk("R2 no write holds", rd_data, 32'hCFFF_5AFF);

    // inputs 0..3 codes 00,01,10,11
    write_reg(4'hF, 32'h0000_00E4);
    drive(16'h0002, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, "R4 code01 smi");
    chk("R4 smi high", {31'd0, smi_req}, 32'd1);
    drive(16'h0002, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0, "R4 smi_en off");
    chk("R4 smi gated", {31'd0, smi_req}, 32'd0);
    drive(16'h0004, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0, "R5 code10 sci");
    chk("R5 sci high", {31'd0, sci_req}, 32'd1);
    drive(16'h0009, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, "R6 codes 00/11");
    chk("R6 silent", {30'd0, smi_req, sci_req}, 32'd0);
    drive(16'h0006, 16'hFFF9, 16'hFFFF, 16'hFFFF, 1'b0, "R7 outputs pins");
    chk("R7 silent", {29'd0, smi_req, sci_req, wake_req}, 32'd0);
    drive(16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, "R8 no status");
    chk("R8 silent", {29'd0, smi_req, sci_req, wake_req}, 32'd0);
    drive(16'h0001, 16'hFFFF, 16'h0000, 16'h0001, 1'b1, "R9 wake route00");
    chk("R9 wake high", {31'd0, wake_req}, 32'd1);
    drive(16'h0001, 16'hFFFF, 16'h0000, 16'h0001, 1'b0, "R9 awake");
    chk("R9 wake low", {31'd0, wake_req}, 32'd0);
    drive(16'h4000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, "R3 unimpl input");
    chk("R3 unimpl silent", {31'd0, wake_req}, 32'd0);
    // R10: OR of two inputs, same-cycle tracking
    drive(16'h0006, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, "R10 both");
    chk("R10 both high", {30'd0, smi_req, sci_req}, 32'd3);
    drive(16'h0004, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, "R10 drop one");
    chk("R10 smi drops", {30'd0, smi_req, sci_req}, 32'd1);

    for (int it = 0; it < 600; it++) begin
      if (($urandom % 5) == 0) write_reg(4'($urandom), $urandom);
      drive(16'($urandom & $urandom & $urandom), 16'($urandom | $urandom),
            16'($urandom), 16'($urandom), 1'($urandom), "R10 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule